// File: doc/BRIEF.md
# I/O Window Address Decoder

This block sits between a 40-bit system bus and a 32-bit I/O bus and decides which system-bus requests are claimed by the I/O side. Each request address is checked against two programmable address windows. The 2-bit forwarding mode then decides what happens to a matching request: it is dropped, passed through, or (for short writes only) redirected into the broadcast region of the I/O space. For every forwarded request the block also builds the 32-bit I/O-bus address.

Software programs the windows and the mode through a simple register write port. A request is a single-cycle strobe that carries an address, a write flag and a short-transfer flag. The result appears one clock later as a forward strobe with the remapped address, the write flag, and a per-window hit vector. In the text below, bit numbers are LSB-first (bit 0 is the least significant bit).

Top module: `iowin_decoder`

## Requirements
- R1: After reset the mode is off (0) and each window's low and high bounds are both zero, so no window is open. With no configuration written, every request gives `win_hit_o == 0` and no forward.
- R2: An address hits window w only if all of these hold: `addr[39:32]` is all ones; `addr[31:28]` equals `low_w[15:12]`; and `addr[27:16]` is greater than or equal to `low_w[11:0]` and less than `high_w[11:0]`.
- R3: Address bits `[15:0]` have no effect on whether a request hits.
- R4: A window whose `low_w[11:0]` is greater than or equal to its `high_w[11:0]` is empty and never hits.
- R5: The two windows are checked independently. `win_hit_o[w]` reports a hit in window w, and a hit in either window is enough to forward the request.
- R6: In mode 0 (off) and mode 2 (reserved), no request is forwarded. `win_hit_o` still reports matches.
- R7: In mode 1 (include), every request that hits a window is forwarded, whether it is a read or a write. The forwarded address is `{4'hF, addr[27:2], 2'b00}` and `fwd_write_o` copies the request's write flag.
- R8: In mode 3 (peek), only requests that hit a window and are both a write and short are forwarded. Their address is the R7 address with bits `[31:18]` forced to ones.
- R9: All outputs are registered one cycle after the request. When nothing is forwarded, `fwd_addr_o` and `fwd_write_o` are zero. In a cycle with no request, `win_hit_o` is zero.
- R10: A configuration write applies to any request presented in the following cycle or later. A request presented in the same cycle as the write is still compared against the old value.
- R11: `cfg_sel_i` selects the register to write: 0 = low of window 0, 1 = high of window 0, 2 = low of window 1, 3 = high of window 1, 4 = mode (from `cfg_wdata_i[1:0]`). Values 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Configuration register select |
| cfg_wdata_i | input | 32 | Configuration write data |
| req_valid_i | input | 1 | Request strobe |
| req_addr_i | input | 40 | System-bus request address |
| req_write_i | input | 1 | Request is a write |
| req_short_i | input | 1 | Request is a short transfer |
| fwd_valid_o | output | 1 | Request forwarded to the I/O bus |
| fwd_addr_o | output | 32 | Remapped I/O-bus address |
| fwd_write_o | output | 1 | Forwarded request is a write |
| win_hit_o | output | 2 | Per-window hit for the previous request |

## Verification
Every result (forward strobe, remapped address, write flag and hit vector) is registered once, so it is due one clock after the edge that captures the request. The bench drives each request on a falling edge and reads all four outputs on the next falling edge, which is half a cycle after the capturing edge. A configuration write is held for exactly one edge, and the bench then presents the next request in the very next cycle, so each check probes the earliest point at which a new bound or mode can take effect.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_INCL = 2'd1,
    MODE_RSVD = 2'd2,
    MODE_PEEK = 2'd3
  } fwd_mode_e;
endpackage

// File: rtl/iowin_cfg.sv
module iowin_cfg
  import iowin_pkg::*;
#(
  parameter int NUM_WIN = 2,
  parameter int REG_W   = 32,
  parameter int SEL_W   = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [SEL_W-1:0]         sel_i,
  input  logic [REG_W-1:0]         wdata_i,
  output logic [NUM_WIN*REG_W-1:0] lo_o,
  output logic [NUM_WIN*REG_W-1:0] hi_o,
  output fwd_mode_e                mode_o
);
  localparam logic [SEL_W-1:0] MODE_SEL = SEL_W'(2 * NUM_WIN);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam logic [SEL_W-1:0] LO_SEL = SEL_W'(2 * w);
    localparam logic [SEL_W-1:0] HI_SEL = SEL_W'(2 * w + 1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_o[w*REG_W +: REG_W] <= '0;
        hi_o[w*REG_W +: REG_W] <= '0;
      end else if (we_i) begin
        if (sel_i == LO_SEL) lo_o[w*REG_W +: REG_W] <= wdata_i;
        if (sel_i == HI_SEL) hi_o[w*REG_W +: REG_W] <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_o <= MODE_OFF;
    else if (we_i && sel_i == MODE_SEL) mode_o <= fwd_mode_e'(wdata_i[1:0]);
  end
endmodule

// File: rtl/iowin_match.sv
module iowin_match #(
  parameter int ADDR_W   = 40,
  parameter int REG_W    = 32,
  parameter int PREFIX_W = 8,
  parameter int SEG_W    = 4,
  parameter int RANGE_W  = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  lo_i,
  input  logic [REG_W-1:0]  hi_i,
  output logic              hit_o
);
  localparam int PREFIX_LSB = ADDR_W - PREFIX_W;
  localparam int SEG_LSB    = PREFIX_LSB - SEG_W;
  localparam int RANGE_LSB  = SEG_LSB - RANGE_W;

  logic               prefix_ok, seg_ok, win_open, above_lo, below_hi;
  logic [RANGE_W-1:0] a_rng, lo_rng, hi_rng;
  logic [SEG_W-1:0]   a_seg, lo_seg;

  assign a_rng  = addr_i[RANGE_LSB +: RANGE_W];
  assign a_seg  = addr_i[SEG_LSB +: SEG_W];
  assign lo_rng = lo_i[RANGE_W-1:0];
  assign hi_rng = hi_i[RANGE_W-1:0];
  assign lo_seg = lo_i[RANGE_W +: SEG_W];

  always_comb begin
    prefix_ok = &addr_i[ADDR_W-1:PREFIX_LSB];
    seg_ok    = (a_seg == lo_seg);
    win_open  = (lo_rng < hi_rng);
    above_lo  = (a_rng >= lo_rng);
    below_hi  = (a_rng < hi_rng);
    hit_o     = prefix_ok & seg_ok & win_open & above_lo & below_hi;
  end
endmodule

// File: rtl/iowin_remap.sv
module iowin_remap #(
  parameter int ADDR_W  = 40,
  parameter int IO_W    = 32,
  parameter int TAG_W   = 4,
  parameter int BCAST_W = 14,
  parameter int SEG_LSB = 28
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              bcast_i,
  output logic [IO_W-1:0]   io_addr_o
);
  localparam int PASS_W = IO_W - TAG_W - 2;
  localparam logic [IO_W-1:0] BCAST_MASK = {{BCAST_W{1'b1}}, {(IO_W-BCAST_W){1'b0}}};

  logic [IO_W-1:0] base;
  assign base = {{TAG_W{1'b1}}, addr_i[SEG_LSB-1 -: PASS_W], 2'b00};

  always_comb begin
    io_addr_o = base;
    if (bcast_i) io_addr_o = base | BCAST_MASK;
  end
endmodule

// File: rtl/iowin_decoder.sv
module iowin_decoder
  import iowin_pkg::*;
#(
  parameter int ADDR_W   = 40,
  parameter int IO_W     = 32,
  parameter int REG_W    = 32,
  parameter int NUM_WIN  = 2,
  parameter int PREFIX_W = 8,
  parameter int SEG_W    = 4,
  parameter int RANGE_W  = 12,
  parameter int TAG_W    = 4,
  parameter int BCAST_W  = 14,
  parameter int SEL_W    = $clog2(2 * NUM_WIN + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [SEL_W-1:0]   cfg_sel_i,
  input  logic [REG_W-1:0]   cfg_wdata_i,
  input  logic               req_valid_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic               req_write_i,
  input  logic               req_short_i,
  output logic               fwd_valid_o,
  output logic [IO_W-1:0]    fwd_addr_o,
  output logic               fwd_write_o,
  output logic [NUM_WIN-1:0] win_hit_o
);
  localparam int SEG_LSB = ADDR_W - PREFIX_W - SEG_W;

  logic [NUM_WIN*REG_W-1:0] lo_flat, hi_flat;
  fwd_mode_e                mode_q;
  logic [NUM_WIN-1:0]       hit_vec;
  logic                     any_hit, fwd_d, peek;
  logic [IO_W-1:0]          io_addr;

  iowin_cfg #(.NUM_WIN(NUM_WIN), .REG_W(REG_W), .SEL_W(SEL_W)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i),
    .lo_o(lo_flat), .hi_o(hi_flat), .mode_o(mode_q)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
    iowin_match #(
      .ADDR_W(ADDR_W), .REG_W(REG_W), .PREFIX_W(PREFIX_W),
      .SEG_W(SEG_W), .RANGE_W(RANGE_W)
    ) u_match (
      .addr_i(req_addr_i),
      .lo_i(lo_flat[w*REG_W +: REG_W]),
      .hi_i(hi_flat[w*REG_W +: REG_W]),
      .hit_o(hit_vec[w])
    );
  end

  assign any_hit = |hit_vec;
  assign peek    = (mode_q == MODE_PEEK);

  iowin_remap #(
    .ADDR_W(ADDR_W), .IO_W(IO_W), .TAG_W(TAG_W),
    .BCAST_W(BCAST_W), .SEG_LSB(SEG_LSB)
  ) u_remap (
    .addr_i(req_addr_i), .bcast_i(peek), .io_addr_o(io_addr)
  );

  always_comb begin
    fwd_d = 1'b0;
    unique case (mode_q)
      MODE_INCL: fwd_d = req_valid_i & any_hit;
      MODE_PEEK: fwd_d = req_valid_i & any_hit & req_write_i & req_short_i;
      default:   fwd_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fwd_valid_o <= 1'b0;
      fwd_addr_o  <= '0;
      fwd_write_o <= 1'b0;
      win_hit_o   <= '0;
    end else begin
      fwd_valid_o <= fwd_d;
      fwd_addr_o  <= fwd_d ? io_addr : '0;
      fwd_write_o <= fwd_d & req_write_i;
      win_hit_o   <= req_valid_i ? hit_vec : '0;
    end
  end
endmodule

// File: rtl/iowin_decoder_chk.sv
module iowin_decoder_chk #(
  parameter int ADDR_W  = 40,
  parameter int IO_W    = 32,
  parameter int REG_W   = 32,
  parameter int NUM_WIN = 2,
  parameter int RANGE_W = 12,
  parameter int BCAST_W = 14
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     req_valid_i,
  input logic [ADDR_W-1:0]        req_addr_i,
  input logic [1:0]               mode_q,
  input logic [NUM_WIN*REG_W-1:0] lo_flat,
  input logic [NUM_WIN*REG_W-1:0] hi_flat,
  input logic                     fwd_valid_o,
  input logic [IO_W-1:0]          fwd_addr_o,
  input logic                     fwd_write_o,
  input logic [NUM_WIN-1:0]       win_hit_o
);
  // R5
  fwd_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |-> (win_hit_o != '0));

  // R7
  fwd_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |-> (fwd_addr_o[IO_W-1:IO_W-4] == 4'hF && fwd_addr_o[1:0] == 2'b00));

  // R3
  addr_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |-> (fwd_addr_o[IO_W-BCAST_W-1:2] == $past(req_addr_i[IO_W-BCAST_W-1:2])));

  // R9
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fwd_valid_o |-> (fwd_addr_o == '0 && !fwd_write_o));

  // R9
  no_req_no_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(req_valid_i) |-> (win_hit_o == '0 && !fwd_valid_o));

  // R6
  off_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_q) == 2'd0 || $past(mode_q) == 2'd2) |-> !fwd_valid_o);

  // R8
  peek_bcast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_q) == 2'd3 && fwd_valid_o) |->
      (&fwd_addr_o[IO_W-1:IO_W-BCAST_W] && fwd_write_o));

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_empty
    // R4
    empty_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      win_hit_o[w] |->
        ($past(lo_flat[w*REG_W +: RANGE_W]) < $past(hi_flat[w*REG_W +: RANGE_W])));
  end
endmodule

bind iowin_decoder iowin_decoder_chk #(
  .ADDR_W(ADDR_W), .IO_W(IO_W), .REG_W(REG_W), .NUM_WIN(NUM_WIN),
  .RANGE_W(RANGE_W), .BCAST_W(BCAST_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
  .mode_q(mode_q), .lo_flat(lo_flat), .hi_flat(hi_flat),
  .fwd_valid_o(fwd_valid_o), .fwd_addr_o(fwd_addr_o), .fwd_write_o(fwd_write_o),
  .win_hit_o(win_hit_o)
);

// File: tb/sim_iowin_decoder.sv
module sim_iowin_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_sel_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic        req_valid_i = 1'b0;
  logic [39:0] req_addr_i = '0;
  logic        req_write_i = 1'b0;
  logic        req_short_i = 1'b0;
  logic        fwd_valid_o;
  logic [31:0] fwd_addr_o;
  logic        fwd_write_o;
  logic [1:0]  win_hit_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] m_lo [2];
  logic [31:0] m_hi [2];
  logic [1:0]  m_mode;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  iowin_decoder u0 (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic m_hit(input logic [39:0] a, input int w);
    return (a[39:32] == 8'hFF) && (a[31:28] == m_lo[w][15:12]) &&
           (a[27:16] >= m_lo[w][11:0]) && (a[27:16] < m_hi[w][11:0]);
  endfunction

  function automatic logic m_fwd(input logic [39:0] a, input logic wr, input logic sh);
    logic h = m_hit(a, 0) | m_hit(a, 1);
    case (m_mode)
      2'd1:    return h;
      2'd3:    return h & wr & sh;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] m_addr(input logic [39:0] a);
    logic [31:0] r = {4'hF, a[27:2], 2'b00};
    if (m_mode == 2'd3) r[31:18] = '1;
    return r;
  endfunction

  // entered at a falling edge, leaves at a falling edge
  task automatic cfg(input logic [2:0] sel, input logic [31:0] d);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    case (sel)
      3'd0: m_lo[0] = d;
      3'd1: m_hi[0] = d;
      3'd2: m_lo[1] = d;
      3'd3: m_hi[1] = d;
      3'd4: m_mode = d[1:0];
      default: ;
    endcase
  endtask

  task automatic req(input string tag, input logic [39:0] a, input logic wr, input logic sh);
    logic f;
    req_valid_i = 1'b1; req_addr_i = a; req_write_i = wr; req_short_i = sh;
    f = m_fwd(a, wr, sh);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk({tag, " hit"}, 64'(win_hit_o), 64'({m_hit(a, 1), m_hit(a, 0)}));
    chk({tag, " fwd"}, 64'(fwd_valid_o), 64'(f));
    chk({tag, " addr"}, 64'(fwd_addr_o), f ? 64'(m_addr(a)) : 64'd0);
    chk({tag, " wr"}, 64'(fwd_write_o), 64'(f & wr));
  endtask

  function automatic logic [39:0] mk(input logic [7:0] p, input logic [3:0] s,
                                     input logic [11:0] r, input logic [15:0] lo);
    return {p, s, r, lo};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    m_lo = '{default: '0}; m_hi = '{default: '0}; m_mode = 2'd0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 rst fwd", 64'(fwd_valid_o), 0);
    chk("R1 rst addr", 64'(fwd_addr_o), 0);
    chk("R1 rst hit", 64'(win_hit_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    req("R1 closed", mk(8'hFF, 4'h0, 12'h000, 16'h0), 1'b0, 1'b0);
    chk("R1 closed hit", 64'(win_hit_o), 0);

    // R11 select encoding, R10 next-cycle effect
    cfg(3'd0, 32'h0000_5100);
    cfg(3'd1, 32'h0000_0200);
    cfg(3'd4, 32'd1);
    req("R10 next cycle", mk(8'hFF, 4'h5, 12'h150, 16'h1234), 1'b0, 1'b0);
    chk("R10 fwd", 64'(fwd_valid_o), 1);

    // R2 boundaries and three-part match
    req("R2 lo edge", mk(8'hFF, 4'h5, 12'h100, 16'h0), 1'b1, 1'b0);
    req("R2 hi-1", mk(8'hFF, 4'h5, 12'h1FF, 16'h0), 1'b1, 1'b0);
    req("R2 hi edge", mk(8'hFF, 4'h5, 12'h200, 16'h0), 1'b1, 1'b0);
    chk("R2 hi edge miss", 64'(win_hit_o), 0);
    req("R2 below lo", mk(8'hFF, 4'h5, 12'h0FF, 16'h0), 1'b0, 1'b0);
    req("R2 seg", mk(8'hFF, 4'h6, 12'h150, 16'h0), 1'b0, 1'b0);
    req("R2 prefix", mk(8'hFE, 4'h5, 12'h150, 16'h0), 1'b0, 1'b0);
    chk("R2 prefix miss", 64'(fwd_valid_o), 0);

    // R3 low address bits ignored
    req("R3 ffff", mk(8'hFF, 4'h5, 12'h180, 16'hFFFF), 1'b0, 1'b0);
    req("R3 0000", mk(8'hFF, 4'h5, 12'h180, 16'h0000), 1'b0, 1'b0);
    chk("R3 hit", 64'(win_hit_o), 1);

    // R4 empty window
    cfg(3'd2, 32'h0000_7300);
    cfg(3'd3, 32'h0000_0300);
    req("R4 equal", mk(8'hFF, 4'h7, 12'h300, 16'h0), 1'b0, 1'b0);
    cfg(3'd3, 32'h0000_0200);
    req("R4 inverted", mk(8'hFF, 4'h7, 12'h250, 16'h0), 1'b0, 1'b0);
    chk("R4 miss", 64'(win_hit_o), 0);

    // R5 second window independent
    cfg(3'd3, 32'h0000_0400);
    req("R5 win1", mk(8'hFF, 4'h7, 12'h3FF, 16'h0), 1'b1, 1'b1);
    chk("R5 vec", 64'(win_hit_o), 2);
    req("R5 win0", mk(8'hFF, 4'h5, 12'h101, 16'h0), 1'b1, 1'b1);
    chk("R5 vec0", 64'(win_hit_o), 1);

    // R7 include: reads and writes
    req("R7 read", mk(8'hFF, 4'h5, 12'h1AB, 16'hC00D), 1'b0, 1'b0);
    chk("R7 addr", 64'(fwd_addr_o), 64'(32'hF1AB_C00C));

    // R11 select 5..7 ignored (mode stays include)
    cfg(3'd5, 32'd0);
    cfg(3'd7, 32'd0);
    req("R11 ignored", mk(8'hFF, 4'h5, 12'h150, 16'h0), 1'b0, 1'b0);
    chk("R11 still fwd", 64'(fwd_valid_o), 1);

    // R6 off and reserved
    cfg(3'd4, 32'd0);
    req("R6 off", mk(8'hFF, 4'h5, 12'h150, 16'h0), 1'b1, 1'b1);
    chk("R6 off hit kept", 64'(win_hit_o), 1);
    cfg(3'd4, 32'd2);
    req("R6 rsvd", mk(8'hFF, 4'h7, 12'h350, 16'h0), 1'b1, 1'b1);
    chk("R6 rsvd nofwd", 64'(fwd_valid_o), 0);

    // R8 peek
    cfg(3'd4, 32'd3);
    req("R8 short wr", mk(8'hFF, 4'h5, 12'h1AB, 16'hC00D), 1'b1, 1'b1);
    chk("R8 bcast", 64'(fwd_addr_o), 64'(32'hFFFF_C00C));
    req("R8 read", mk(8'hFF, 4'h5, 12'h1AB, 16'h0), 1'b0, 1'b1);
    req("R8 long wr", mk(8'hFF, 4'h5, 12'h1AB, 16'h0), 1'b1, 1'b0);
    chk("R8 long nofwd", 64'(fwd_valid_o), 0);

    // R9 idle cycle gives no hit
    @(negedge clk_i);
    chk("R9 idle hit", 64'(win_hit_o), 0);
    chk("R9 idle fwd", 64'(fwd_valid_o), 0);

    // R10 same-cycle write uses old bound
    cfg(3'd4, 32'd1);
    cfg_we_i = 1'b1; cfg_sel_i = 3'd1; cfg_wdata_i = 32'h0000_0100;
    req("R10 same cycle", mk(8'hFF, 4'h5, 12'h180, 16'h0), 1'b0, 1'b0);
    chk("R10 old bound", 64'(win_hit_o), 1);
    cfg_we_i = 1'b0;
    m_hi[0] = 32'h0000_0100;
    req("R10 after", mk(8'hFF, 4'h5, 12'h0F0, 16'h0), 1'b0, 1'b0);

    // R2 random mix against model
    void'($urandom(32'h1F0D));
    for (int i = 0; i < 2000; i++) begin
      logic [39:0] a;
      logic [3:0]  s;
      if (i % 16 == 0) begin
        logic [2:0]  sel = 3'($urandom_range(0, 7));
        logic [31:0] d = $urandom;
        cfg(sel, d);
      end
      s = ($urandom_range(0, 2) == 0) ? 4'($urandom) :
          ($urandom_range(0, 1) != 0) ? m_lo[0][15:12] : m_lo[1][15:12];
      a = mk(($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'hFF, s,
             12'($urandom), 16'($urandom));
      if ($urandom_range(0, 3) == 0) @(negedge clk_i);
      req("R2 random", a, 1'($urandom), 1'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule